// File: doc/BRIEF.md
# Video Lock Qualifier with Free-Run Substitution

This block sits behind a video sync processor that raises a raw lock indication once per line. It filters that indication into a stable lock status with line-count hysteresis. Lock has to hold for a programmable number of consecutive lines before the status goes high. Loss of lock has to hold for a separately programmable number of lines before the status drops. Alongside the live status bit, a sticky flag records that lock was lost at some point. That flag stays set until a status read strobe clears it.

The block also carries the 4:2:2 pixel stream on its way to the output. When lock is absent and automatic free-run is enabled, or whenever forcing is enabled, it replaces luma and chroma with flat default colour values taken from registers. The decision to substitute is taken only at line boundaries, so no line is ever partly replaced. A small write-only register port sets the control bits and the default colours.

Top module: `vlock_guard`

## Requirements
- R1: After reset, stat_locked, stat_lost, out_y and out_c are all 0, and substitution is active.
- R2: A 3-bit lock-in code selects how many consecutive line strobes with raw_lock high are needed before stat_locked rises. The codes 0..7 map to 1, 2, 5, 10, 20, 50, 100 and 200 lines.
- R3: A 3-bit lock-out code, using the same line mapping as R2, selects how many consecutive line strobes with raw_lock low are needed before stat_locked falls.
- R4: A line strobe whose raw_lock matches the current stat_locked value restarts the run count toward a change.
- R5: stat_locked changes only on the clock edge where line_stb is high.
- R6: stat_lost becomes 1 on the edge where stat_locked falls and holds until a stat_rd strobe. A stat_rd strobe clears it on the edge where stat_rd is high.
- R7: If stat_locked falls on the same edge where stat_rd is high, stat_lost still ends up set.
- R8: When the force bit is set at a line strobe, that line is substituted whether or not the block is locked.
- R9: When the force bit is clear, a line is substituted exactly when the auto bit is set and the lock state after that strobe is unlocked. With both bits clear, pixels pass through unchanged.
- R10: Substituted luma is {def_y[5:0], 2'b00}. Substituted chroma is {def_c[7:4], 4'h0} on Cr samples (pix_c_is_cr = 1) and {def_c[3:0], 4'h0} on Cb samples. After reset def_c is 0x7C and def_y is 0x04.
- R11: The substitute-or-pass decision is latched at each line strobe. It applies from the pixel that arrives with the strobe until the next strobe, even if the control register changes in between.
- R12: out_y and out_c show the pixel, or its substitute, one clock after the pixel is presented.
- R13: Register writes select by reg_sel. 0 is control: bit0 force, bit1 auto, bits[4:2] lock-in code, bits[7:5] lock-out code, reset value 0x4A. 1 is def_y from bits[5:0]. 2 is def_c. A write to 3 changes nothing. A write takes effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe that comes with the first pixel of each line |
| raw_lock | input | 1 | Unqualified lock indication, sampled at line_stb |
| pix_y | input | 8 | Incoming luma sample |
| pix_c | input | 8 | Incoming chroma sample |
| pix_c_is_cr | input | 1 | 1 when pix_c carries Cr, 0 when it carries Cb |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe; clears the sticky flag |
| stat_locked | output | 1 | Qualified lock status |
| stat_lost | output | 1 | Sticky lost-lock flag |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |

## Verification
The bench aims at the off-by-one edges of the line counters. It runs a line short of the threshold and then exactly at it, and it breaks a run with one agreeing line. A counter that compares with the wrong bound, or that never restarts, changes lock one line early or late. It drives a lock drop on the same cycle as a status read: a design that lets the read win would lose the only record of the event. It also changes the control bits in mid-line and checks the nibble packing of the chroma default on both Cr and Cb samples. A decision that is not latched would tear a line, and swapped nibbles would put the wrong colour on screen.

// File: rtl/vlg_pkg.sv
package vlg_pkg;

   typedef struct packed {
      logic [2:0] out_code;
      logic [2:0] in_code;
      logic       auto_en;
      logic       force_en;
   } ctrl_t;

   localparam logic [7:0] CTRL_RST = 8'h4A;

   function automatic logic [7:0] lines_for_code(input logic [2:0] code);
      logic [7:0] n;
      case (code)
         3'd0:    n = 8'd1;
         3'd1:    n = 8'd2;
         3'd2:    n = 8'd5;
         3'd3:    n = 8'd10;
         3'd4:    n = 8'd20;
         3'd5:    n = 8'd50;
         3'd6:    n = 8'd100;
         default: n = 8'd200;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/vlg_regs.sv
module vlg_regs
   import vlg_pkg::*;
#(
   parameter int Y_W = 8,
   parameter int C_W = 8,
   parameter int REG_W = 8,
   parameter logic [C_W-1:0] DEF_C_RST = 'h7C,
   parameter logic [Y_W-3:0] DEF_Y_RST = 'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output ctrl_t            ctrl,
   output logic [Y_W-3:0]   def_y,
   output logic [C_W-1:0]   def_c
);
   localparam int DY_W = Y_W - 2;

   if (DY_W > REG_W || C_W > REG_W) begin : g_bad_width
      $error("default fields wider than register data");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= ctrl_t'(CTRL_RST);
         def_y <= DEF_Y_RST;
         def_c <= DEF_C_RST;
      end else if (wr_en) begin
         case (wr_sel)
            2'd0:    ctrl  <= ctrl_t'(wr_data[7:0]);
            2'd1:    def_y <= wr_data[DY_W-1:0];
            2'd2:    def_c <= wr_data[C_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vlg_lock_fsm.sv
module vlg_lock_fsm
   import vlg_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_stb,
   input  logic       raw_lock,
   input  logic [2:0] in_code,
   input  logic [2:0] out_code,
   output logic       locked,
   output logic       lock_nxt,
   output logic       drop
);
   localparam int RUN_W = CNT_W + 1;

   if (CNT_W < 8) begin : g_bad_cnt
      $error("CNT_W must hold a run of 200 lines");
   end

   logic [CNT_W-1:0] run_q, run_nxt;
   logic [RUN_W-1:0] run_inc, target;

   assign target  = RUN_W'(lines_for_code(locked ? out_code : in_code));
   assign run_inc = {1'b0, run_q} + 1'b1;

   always_comb begin
      lock_nxt = locked;
      run_nxt  = run_q;
      drop     = 1'b0;
      if (line_stb) begin
         if (raw_lock == locked) begin
            run_nxt = '0;
         end else if (run_inc >= target) begin
            lock_nxt = raw_lock;
            run_nxt  = '0;
            drop     = locked;
         end else begin
            run_nxt = run_inc[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         run_q  <= '0;
      end else begin
         locked <= lock_nxt;
         run_q  <= run_nxt;
      end
   end

   // R5
   lock_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(locked));

   // R2
   rise_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(raw_lock));
endmodule

// File: rtl/vlg_sticky.sv
module vlg_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   // R7
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/vlg_subst.sv
module vlg_subst #(
   parameter int Y_W = 8,
   parameter int C_W = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_stb,
   input  logic           decide,
   input  logic [Y_W-3:0] def_y,
   input  logic [C_W-1:0] def_c,
   input  logic [Y_W-1:0] pix_y,
   input  logic [C_W-1:0] pix_c,
   input  logic           pix_c_is_cr,
   output logic [Y_W-1:0] out_y,
   output logic [C_W-1:0] out_c
);
   localparam int HALF = C_W / 2;

   if ((C_W % 2) != 0 || Y_W < 4) begin : g_bad_fmt
      $error("chroma width must be even and luma at least 4 bits");
   end

   logic           subst_q, subst_now;
   logic [Y_W-1:0] sel_y, flat_y;
   logic [C_W-1:0] sel_c, flat_c;

   assign subst_now = line_stb ? decide : subst_q;
   assign flat_y    = {def_y, 2'b00};
   assign flat_c    = pix_c_is_cr ? {def_c[C_W-1:HALF], {HALF{1'b0}}}
                                  : {def_c[HALF-1:0], {HALF{1'b0}}};
   assign sel_y     = subst_now ? flat_y : pix_y;
   assign sel_c     = subst_now ? flat_c : pix_c;

   always_ff @(posedge clk) begin
      if (!rst_n) subst_q <= 1'b1;
      else        subst_q <= subst_now;
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_y <= '0;
            out_c <= '0;
         end else begin
            out_y <= sel_y;
            out_c <= sel_c;
         end
      end
   end else begin : g_comb_out
      assign out_y = sel_y;
      assign out_c = sel_c;
   end

   // R11
   decision_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(subst_q));
endmodule

// File: rtl/vlock_guard.sv
module vlock_guard
   import vlg_pkg::*;
#(
   parameter int Y_W = 8,
   parameter int C_W = 8,
   parameter int CNT_W = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_stb,
   input  logic           raw_lock,
   input  logic [Y_W-1:0] pix_y,
   input  logic [C_W-1:0] pix_c,
   input  logic           pix_c_is_cr,
   input  logic           reg_wr,
   input  logic [1:0]     reg_sel,
   input  logic [7:0]     reg_wdata,
   input  logic           stat_rd,
   output logic           stat_locked,
   output logic           stat_lost,
   output logic [Y_W-1:0] out_y,
   output logic [C_W-1:0] out_c
);
   ctrl_t          ctrl;
   logic [Y_W-3:0] def_y;
   logic [C_W-1:0] def_c;
   logic           lock_nxt, drop, decide;

   vlg_regs #(.Y_W(Y_W), .C_W(C_W), .REG_W(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
      .wr_data(reg_wdata), .ctrl(ctrl), .def_y(def_y), .def_c(def_c));

   vlg_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .raw_lock(raw_lock),
      .in_code(ctrl.in_code), .out_code(ctrl.out_code),
      .locked(stat_locked), .lock_nxt(lock_nxt), .drop(drop));

   vlg_sticky u_lost (
      .clk(clk), .rst_n(rst_n), .set_i(drop), .clr_i(stat_rd),
      .flag_o(stat_lost));

   assign decide = ctrl.force_en | (ctrl.auto_en & ~lock_nxt);

   vlg_subst #(.Y_W(Y_W), .C_W(C_W), .OUT_REG(OUT_REG)) u_subst (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .decide(decide),
      .def_y(def_y), .def_c(def_c), .pix_y(pix_y), .pix_c(pix_c),
      .pix_c_is_cr(pix_c_is_cr), .out_y(out_y), .out_c(out_c));

   // R6
   fall_sets_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_locked) |-> stat_lost);

   if (OUT_REG) begin : g_force_chk
      // R8
      force_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (line_stb && ctrl.force_en) |=> (out_y == {$past(def_y), 2'b00}));
   end
endmodule

// File: tb/vlock_guard_tb.sv
module vlock_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 0, raw_lock = 0, pix_c_is_cr = 0;
   logic [7:0] pix_y = 0, pix_c = 0;
   logic       reg_wr = 0, stat_rd = 0;
   logic [1:0] reg_sel = 0;
   logic [7:0] reg_wdata = 0;
   logic       stat_locked, stat_lost;
   logic [7:0] out_y, out_c;

   int n_tests = 0, n_fail = 0;

   // bench model state
   logic [7:0] m_ctrl, m_defc, m_y, m_c;
   logic [5:0] m_defy;
   logic       m_locked, m_lost, m_sub;
   int         m_run;

   always #5 clk = ~clk;

   vlock_guard u_dut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .raw_lock(raw_lock),
      .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .stat_rd(stat_rd), .stat_locked(stat_locked), .stat_lost(stat_lost),
      .out_y(out_y), .out_c(out_c));

   function automatic int lines_of(input logic [2:0] code);
      case (code)
         3'd0: return 1;   3'd1: return 2;   3'd2: return 5;  3'd3: return 10;
         3'd4: return 20;  3'd5: return 50;  3'd6: return 100;
         default: return 200;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      int  tgt;
      logic nl, drop;
      tgt  = lines_of(m_locked ? m_ctrl[7:5] : m_ctrl[4:2]);
      nl   = m_locked;
      drop = 0;
      if (line_stb) begin
         if (raw_lock == m_locked) m_run = 0;
         else if (m_run + 1 >= tgt) begin
            nl = raw_lock; m_run = 0; drop = m_locked;
         end else m_run++;
         m_sub = m_ctrl[0] | (m_ctrl[1] & ~nl);
      end
      m_lost   = drop ? 1'b1 : (stat_rd ? 1'b0 : m_lost);
      m_locked = nl;
      m_y = m_sub ? {m_defy, 2'b00} : pix_y;
      m_c = m_sub ? (pix_c_is_cr ? {m_defc[7:4], 4'h0} : {m_defc[3:0], 4'h0}) : pix_c;
      if (reg_wr) begin
         case (reg_sel)
            2'd0: m_ctrl = reg_wdata;
            2'd1: m_defy = reg_wdata[5:0];
            2'd2: m_defc = reg_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic step(input logic ln, input logic rw, input logic [7:0] y,
                       input logic [7:0] c, input logic cs, input logic rd,
                       input logic we, input logic [1:0] sel, input logic [7:0] wd);
      line_stb = ln; raw_lock = rw; pix_y = y; pix_c = c; pix_c_is_cr = cs;
      stat_rd = rd; reg_wr = we; reg_sel = sel; reg_wdata = wd;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R5 R2 R3 locked", {7'd0, stat_locked}, {7'd0, m_locked});
      chk("R6 lost", {7'd0, stat_lost}, {7'd0, m_lost});
      chk("R12 out_y", out_y, m_y);
      chk("R12 out_c", out_c, m_c);
   endtask

   task automatic pix(input logic [7:0] y, input logic cs);
      step(0, raw_lock, y, 8'h33, cs, 0, 0, 0, 0);
   endtask

   task automatic line(input logic rw);
      step(1, rw, 8'h60, 8'h44, 1, 0, 0, 0, 0);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      step(0, raw_lock, 8'h61, 8'h45, 0, 0, 1, sel, d);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ctrl = 8'h4A; m_defc = 8'h7C; m_defy = 6'h04;
      m_locked = 0; m_lost = 0; m_sub = 1; m_run = 0; m_y = 0; m_c = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 locked", {7'd0, stat_locked}, 8'd0);
      chk("R1 lost", {7'd0, stat_lost}, 8'd0);
      chk("R1 out_y", out_y, 8'd0);
      chk("R1 out_c", out_c, 8'd0);

      // R10 reset defaults: Y 0x10, Cr 0x70, Cb 0xC0
      pix(8'h55, 1);
      chk("R10 def Y", out_y, 8'h10);
      chk("R10 def Cr", out_c, 8'h70);
      pix(8'h55, 0);
      chk("R10 def Cb", out_c, 8'hC0);

      // R2 five lines needed at reset code
      repeat (4) begin line(1); pix(8'h20, 1); end
      chk("R2 not yet", {7'd0, stat_locked}, 8'd0);
      line(1);
      chk("R2 locked at 5", {7'd0, stat_locked}, 8'd1);
      pix(8'h55, 1);
      chk("R9 pass when locked", out_y, 8'h55);

      // R4 restart of run, R3 drop after five
      repeat (3) line(0);
      line(1);
      repeat (4) line(0);
      chk("R4 run restarted", {7'd0, stat_locked}, 8'd1);
      line(0);
      chk("R3 dropped", {7'd0, stat_locked}, 8'd0);
      chk("R6 lost set", {7'd0, stat_lost}, 8'd1);
      line(0);
      chk("R6 lost held", {7'd0, stat_lost}, 8'd1);
      step(0, 0, 8'h10, 8'h10, 0, 1, 0, 0, 0);
      chk("R6 read clears", {7'd0, stat_lost}, 8'd0);

      // R7 drop together with read
      wr(2'd0, 8'h02);
      line(1);
      chk("R13 code 0 one line", {7'd0, stat_locked}, 8'd1);
      step(1, 0, 8'h10, 8'h10, 0, 1, 0, 0, 0);
      chk("R7 lost survives read", {7'd0, stat_lost}, 8'd1);

      // R8 force, R11 mid-line change
      wr(2'd0, 8'h01);
      line(1);
      pix(8'h77, 1);
      chk("R8 forced while locked", out_y, 8'h10);
      wr(2'd0, 8'h00);
      pix(8'h77, 1);
      chk("R11 held until strobe", out_y, 8'h10);
      line(1);
      pix(8'h77, 1);
      chk("R11 released at strobe", out_y, 8'h77);
      line(0);
      pix(8'h78, 1);
      chk("R9 no auto pass", out_y, 8'h78);

      // R10 R13 programmed defaults, sel 3 ignored
      wr(2'd1, 8'h3F);
      wr(2'd2, 8'hA5);
      wr(2'd3, 8'hFF);
      wr(2'd0, 8'h01);
      line(0);
      pix(8'h12, 1);
      chk("R10 prog Y", out_y, 8'hFC);
      chk("R13 prog Cr", out_c, 8'hA0);
      pix(8'h12, 0);
      chk("R13 prog Cb", out_c, 8'h50);

      // random mix
      begin
         logic rs;
         rs = 0;
         for (int i = 0; i < 4000; i++) begin
            logic ln, we;
            logic [7:0] wd;
            logic [1:0] sel;
            ln = ($urandom % 3) == 0;
            if (ln && ($urandom % 5) == 0) rs = ~rs;
            we  = ($urandom % 50) == 0;
            sel = 2'($urandom);
            wd  = 8'($urandom);
            if (sel == 2'd0) wd = {1'b0, wd[6:5], 1'b0, wd[3:2], wd[1], (($urandom % 6) == 0)};
            step(ln, rs, 8'($urandom), 8'($urandom), 1'($urandom),
                 ($urandom % 12) == 0, we, sel, wd);
         end
      end

      summary();
      $finish;
   end
endmodule